// File: doc/BRIEF.md
# Station Address Table and Destination Filter

This block keeps a table of sixteen 48-bit station addresses together with a 16-bit enable mask, and decides for every received frame whether its destination address is wanted. The table is filled from system memory by a load command. The command gives a pointer to a chain of address descriptors and a count of them. The loader reads the address words of each descriptor through a single-outstanding word-read port. After the last descriptor it makes one more read, which supplies the enable mask. When the load is finished it pulses an interrupt-status set bit.

The filter takes the six destination bytes and three mode bits: accept-all-unicast, accept-all-group and accept-broadcast. It applies a fixed priority. The answer appears on registered outputs one clock later, as an accept flag plus a broadcast or multicast tag. While the device is held in its reset mode, the host can read any table entry back as three 16-bit words.

Top module: `cam_addr_filter`

## Requirements
- R1: A load started with `load_start` (ignored while `load_busy` is high) processes exactly as many descriptors as the value of `load_cnt[4:0]`; higher count bits have no effect. Descriptor e is written into table entry e.
- R2: Each descriptor is four words starting at its pointer P. The address of word k is P+2k in 16-bit mode (`wide_mode`=0) and P+4k in 32-bit mode. Words 1, 2 and 3 are read in that order, and each carries address bytes 2(k-1) and 2(k-1)+1, the lower-numbered byte in data bits [7:0].
- R3: After each descriptor the pointer advances by 8 bytes in 16-bit mode and by 16 bytes in 32-bit mode.
- R4: After the last descriptor, exactly one more read is made, of word 0 at the advanced pointer. Its data becomes `enable_mask` (bit i enables entry i). With a count of zero, this mask read is the only read.
- R5: The load ends in the cycle the mask data arrives. In the following cycle `load_busy` is low and `irq_set[12]` is high for exactly that one cycle. All other `irq_set` bits are always zero.
- R6: At most one read is outstanding. `mem_req_valid` and `mem_req_addr` stay unchanged until `mem_req_ready`, and no new request is issued before `mem_rsp_valid` returns the data.
- R7: With accept-all-unicast set, a frame whose group bit (bit 0 of byte 0, `flt_da[0]`) is clear is accepted with no tag.
- R8: With accept-all-group set, any frame with the group bit set is accepted and tagged multicast. This includes all-ones, which this rule claims before the broadcast rule can.
- R9: With accept-broadcast set, the all-ones address is accepted and tagged broadcast when no higher rule applies.
- R10: Otherwise a frame is accepted with no tag when it exactly matches an entry whose enable bit is set; entries whose enable bit is clear never match.
- R11: A frame that no rule accepts gives `flt_accept`=0 and both tags 0.
- R12: `flt_out_valid` and the result appear in the cycle after the one in which `flt_valid` is sampled high; `flt_out_valid` is low after a cycle with `flt_valid` low.
- R13: `rd_data` returns the bytes of entry `rd_ptr[3:0]` only while `dev_in_reset` is high. `rd_sel`=0, 1, 2 gives byte pairs {1,0}, {3,2}, {5,4}, with the higher-numbered byte in bits [15:8]. Otherwise `rd_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_start | input | 1 | Start a table load |
| load_ptr | input | 32 | Byte address of the first descriptor |
| load_cnt | input | 16 | Descriptor count (low 5 bits used) |
| wide_mode | input | 1 | 1: 32-bit data mode, 0: 16-bit |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_addr | output | 32 | Read byte address |
| mem_req_ready | input | 1 | Read request accepted |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 16 | Read data word |
| load_busy | output | 1 | Load in progress (command bit) |
| irq_set | output | 16 | Interrupt-status set pulses; bit 12 = load done |
| enable_mask | output | 16 | Per-entry enable |
| dev_in_reset | input | 1 | Device is in its reset mode |
| rd_ptr | input | 16 | Entry pointer for readback (low 4 bits) |
| rd_sel | input | 2 | Readback word select |
| rd_data | output | 16 | Readback data |
| flt_valid | input | 1 | Destination address presented |
| flt_da | input | 48 | Destination bytes, byte i in bits [8i+7:8i] |
| mode_promisc | input | 1 | Accept all unicast |
| mode_allmc | input | 1 | Accept all group addresses |
| mode_bcast | input | 1 | Accept broadcast |
| flt_out_valid | output | 1 | Result valid |
| flt_accept | output | 1 | Frame accepted |
| flt_is_bcast | output | 1 | Accepted as broadcast |
| flt_is_mcast | output | 1 | Accepted as multicast |

## Verification
A loader that keeps a wrong pointer, word index or count shows up on the request address of the very next read. A wrong entry index or byte lane shows up in the readback words as soon as the load completes. A wrong mask or a wrong rule order shows up one cycle after the matching destination is presented, as a flipped accept or tag. The bench therefore records every request address and compares it with the sequence R2 to R4 predict. It reads every loaded entry back, and it walks destinations chosen to sit on each priority boundary.

// File: rtl/cam_addr_filter.sv
module cam_addr_filter #(
  parameter int NUM_ENT       = 16,
  parameter int ADDR_W        = 32,
  parameter int CNT_W         = 16,
  parameter int CNT_LOOP_BITS = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_start,
  input  logic [ADDR_W-1:0]  load_ptr,
  input  logic [CNT_W-1:0]   load_cnt,
  input  logic               wide_mode,
  output logic               mem_req_valid,
  output logic [ADDR_W-1:0]  mem_req_addr,
  input  logic               mem_req_ready,
  input  logic               mem_rsp_valid,
  input  logic [15:0]        mem_rsp_data,
  output logic               load_busy,
  output logic [15:0]        irq_set,
  output logic [NUM_ENT-1:0] enable_mask,
  input  logic               dev_in_reset,
  input  logic [15:0]        rd_ptr,
  input  logic [1:0]         rd_sel,
  output logic [15:0]        rd_data,
  input  logic               flt_valid,
  input  logic [47:0]        flt_da,
  input  logic               mode_promisc,
  input  logic               mode_allmc,
  input  logic               mode_bcast,
  output logic               flt_out_valid,
  output logic               flt_accept,
  output logic               flt_is_bcast,
  output logic               flt_is_mcast
);
  localparam int IDX_W    = $clog2(NUM_ENT);
  localparam int MAC_W    = 48;
  localparam int DONE_BIT = 12;

  typedef enum logic [1:0] {L_IDLE, L_REQ, L_WAIT} lst_t;

  lst_t                     st;
  logic [ADDR_W-1:0]        ptr_q;
  logic [CNT_W-1:0]         cnt_q;
  logic [IDX_W-1:0]         idx_q;
  logic [1:0]               word_q;
  logic                     mask_ph;
  logic                     wide_q;
  logic                     done_q;
  logic [NUM_ENT-1:0]       en_q;
  logic [MAC_W-1:0]         cam_q [NUM_ENT];
  logic [CNT_LOOP_BITS-1:0] cnt_low_dec;
  logic [ADDR_W-1:0]        word_off;
  logic [ADDR_W-1:0]        stride;

  assign cnt_low_dec   = cnt_q[CNT_LOOP_BITS-1:0] - 1'b1;
  assign word_off      = wide_q ? ADDR_W'({word_q, 2'b00}) : ADDR_W'({word_q, 1'b0});
  assign stride        = wide_q ? ADDR_W'(16) : ADDR_W'(8);
  assign mem_req_valid = (st == L_REQ);
  assign mem_req_addr  = ptr_q + word_off;
  assign load_busy     = (st != L_IDLE);
  assign irq_set       = 16'(done_q) << DONE_BIT;
  assign enable_mask   = en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= L_IDLE;
      ptr_q   <= '0;
      cnt_q   <= '0;
      idx_q   <= '0;
      word_q  <= '0;
      mask_ph <= 1'b0;
      wide_q  <= 1'b0;
      done_q  <= 1'b0;
      en_q    <= '0;
      for (int i = 0; i < NUM_ENT; i++) cam_q[i] <= '0;
    end else begin
      done_q <= 1'b0;
      case (st)
        L_IDLE: if (load_start) begin
          ptr_q  <= load_ptr;
          cnt_q  <= load_cnt;
          idx_q  <= '0;
          wide_q <= wide_mode;
          st     <= L_REQ;
          if (load_cnt[CNT_LOOP_BITS-1:0] != '0) begin
            word_q  <= 2'd1;
            mask_ph <= 1'b0;
          end else begin
            word_q  <= 2'd0;
            mask_ph <= 1'b1;
          end
        end
        L_REQ: if (mem_req_ready) st <= L_WAIT;
        L_WAIT: if (mem_rsp_valid) begin
          if (mask_ph) begin
            en_q   <= mem_rsp_data[NUM_ENT-1:0];
            st     <= L_IDLE;
            done_q <= 1'b1;
          end else begin
            case (word_q)
              2'd1:    cam_q[idx_q][15:0]  <= mem_rsp_data;
              2'd2:    cam_q[idx_q][31:16] <= mem_rsp_data;
              default: cam_q[idx_q][47:32] <= mem_rsp_data;
            endcase
            st <= L_REQ;
            if (word_q == 2'd3) begin
              cnt_q <= cnt_q - 1'b1;
              ptr_q <= ptr_q + stride;
              idx_q <= idx_q + 1'b1;
              if (cnt_low_dec == '0) begin
                word_q  <= 2'd0;
                mask_ph <= 1'b1;
              end else begin
                word_q <= 2'd1;
              end
            end else begin
              word_q <= word_q + 1'b1;
            end
          end
        end
        default: st <= L_IDLE;
      endcase
    end
  end

  logic [MAC_W-1:0] rd_ent;
  assign rd_ent = cam_q[rd_ptr[IDX_W-1:0]];

  always_comb begin
    rd_data = '0;
    if (dev_in_reset) begin
      case (rd_sel)
        2'd0:    rd_data = rd_ent[15:0];
        2'd1:    rd_data = rd_ent[31:16];
        2'd2:    rd_data = rd_ent[47:32];
        default: rd_data = '0;
      endcase
    end
  end

  logic [NUM_ENT-1:0] hit;
  for (genvar g = 0; g < NUM_ENT; g++) begin : g_cmp
    assign hit[g] = en_q[g] && (cam_q[g] == flt_da);
  end

  logic grp_bit, all_ones;
  logic acc_d, bc_d, mc_d;
  assign grp_bit  = flt_da[0];
  assign all_ones = &flt_da;

  always_comb begin
    acc_d = 1'b0;
    bc_d  = 1'b0;
    mc_d  = 1'b0;
    if (mode_promisc && !grp_bit) begin
      acc_d = 1'b1;
    end else if (mode_allmc && grp_bit) begin
      acc_d = 1'b1;
      mc_d  = 1'b1;
    end else if (mode_bcast && all_ones) begin
      acc_d = 1'b1;
      bc_d  = 1'b1;
    end else if (|hit) begin
      acc_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flt_out_valid <= 1'b0;
      flt_accept    <= 1'b0;
      flt_is_bcast  <= 1'b0;
      flt_is_mcast  <= 1'b0;
    end else begin
      flt_out_valid <= flt_valid;
      flt_accept    <= flt_valid && acc_d;
      flt_is_bcast  <= flt_valid && bc_d;
      flt_is_mcast  <= flt_valid && mc_d;
    end
  end
endmodule

module cam_addr_filter_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_req_valid,
  input logic [31:0] mem_req_addr,
  input logic        mem_req_ready,
  input logic        load_busy,
  input logic [15:0] irq_set,
  input logic        dev_in_reset,
  input logic [15:0] rd_data,
  input logic        flt_valid,
  input logic        flt_out_valid,
  input logic        flt_accept,
  input logic        flt_is_bcast,
  input logic        flt_is_mcast
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R6
  AST_REQ_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> load_busy); // R6
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_set[12] |-> (!load_busy && $past(load_busy))); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_set[12] |=> !irq_set[12]); // R5
  AST_IRQ_OTHER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_set & 16'hEFFF) == 16'h0); // R5
  AST_TAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(flt_is_bcast && flt_is_mcast)); // R8
  AST_TAG_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_is_bcast || flt_is_mcast) |-> flt_accept); // R9
  AST_RESULT_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    flt_valid |=> flt_out_valid); // R12
  AST_RESULT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !flt_valid |=> !flt_out_valid); // R12
  AST_RD_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !dev_in_reset |-> (rd_data == 16'h0)); // R13
endmodule

bind cam_addr_filter cam_addr_filter_chk chk_i (
  .clk(clk), .rst_n(rst_n), .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
  .mem_req_ready(mem_req_ready), .load_busy(load_busy), .irq_set(irq_set),
  .dev_in_reset(dev_in_reset), .rd_data(rd_data), .flt_valid(flt_valid),
  .flt_out_valid(flt_out_valid), .flt_accept(flt_accept),
  .flt_is_bcast(flt_is_bcast), .flt_is_mcast(flt_is_mcast)
);

// File: tb/cam_addr_filter_tb.sv
`timescale 1ns/1ps
module cam_addr_filter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_start = 1'b0;
  logic [31:0] load_ptr = '0;
  logic [15:0] load_cnt = '0;
  logic        wide_mode = 1'b0;
  logic        mem_req_valid;
  logic [31:0] mem_req_addr;
  logic        mem_req_ready = 1'b0;
  logic        mem_rsp_valid = 1'b0;
  logic [15:0] mem_rsp_data = '0;
  logic        load_busy;
  logic [15:0] irq_set;
  logic [15:0] enable_mask;
  logic        dev_in_reset = 1'b0;
  logic [15:0] rd_ptr = '0;
  logic [1:0]  rd_sel = '0;
  logic [15:0] rd_data;
  logic        flt_valid = 1'b0;
  logic [47:0] flt_da = '0;
  logic        mode_promisc = 1'b0, mode_allmc = 1'b0, mode_bcast = 1'b0;
  logic        flt_out_valid, flt_accept, flt_is_bcast, flt_is_mcast;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  cam_addr_filter dut_i (
    .clk(clk), .rst_n(rst_n), .load_start(load_start), .load_ptr(load_ptr),
    .load_cnt(load_cnt), .wide_mode(wide_mode), .mem_req_valid(mem_req_valid),
    .mem_req_addr(mem_req_addr), .mem_req_ready(mem_req_ready),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .load_busy(load_busy), .irq_set(irq_set), .enable_mask(enable_mask),
    .dev_in_reset(dev_in_reset), .rd_ptr(rd_ptr), .rd_sel(rd_sel), .rd_data(rd_data),
    .flt_valid(flt_valid), .flt_da(flt_da), .mode_promisc(mode_promisc),
    .mode_allmc(mode_allmc), .mode_bcast(mode_bcast), .flt_out_valid(flt_out_valid),
    .flt_accept(flt_accept), .flt_is_bcast(flt_is_bcast), .flt_is_mcast(flt_is_mcast)
  );

  logic [15:0] mem [0:1023];
  logic [31:0] req_log [0:63];
  int          nlog = 0;
  logic [7:0]  lfsr = 8'hA7;

  function automatic logic [15:0] memval(int a);
    return 16'((a * 293) ^ 16'h3C00);
  endfunction

  always @(negedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    mem_req_ready <= lfsr[0] | lfsr[2];
  end

  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    if (mem_req_valid && mem_req_ready) begin
      if (nlog < 64) req_log[nlog] = mem_req_addr;
      nlog = nlog + 1;
      mem_rsp_valid <= 1'b1;
      mem_rsp_data  <= mem[mem_req_addr[10:1]];
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_load(input logic [31:0] p, input logic [15:0] c, input logic w,
                          input string tag);
    int seen_irq = 0;
    nlog = 0;
    @(negedge clk);
    load_ptr = p; load_cnt = c; wide_mode = w; load_start = 1'b1;
    @(negedge clk);
    load_start = 1'b0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (irq_set[12]) begin
        seen_irq = 1;
        chk({tag, " R5 busy low at done"}, 64'(load_busy), 64'h0);
        chk({tag, " R5 irq word"}, 64'(irq_set), 64'h1000);
        @(negedge clk);
        chk({tag, " R5 irq one cycle"}, 64'(irq_set[12]), 64'h0);
        break;
      end
    end
    chk({tag, " R5 done seen"}, 64'(seen_irq), 64'h1);
  endtask

  localparam logic [53:0] VEC [14] = '{
    {3'b000, 48'h554433221102, 3'b100},
    {3'b000, 48'hEEDDCCBBAA02, 3'b000},
    {3'b000, 48'h0700005E0001, 3'b100},
    {3'b000, 48'h050403020106, 3'b000},
    {3'b000, 48'hFFFFFFFFFFFF, 3'b000},
    {3'b001, 48'hFFFFFFFFFFFF, 3'b110},
    {3'b011, 48'hFFFFFFFFFFFF, 3'b101},
    {3'b010, 48'h0700005E0001, 3'b101},
    {3'b100, 48'h665544332210, 3'b100},
    {3'b100, 48'h665544332203, 3'b000},
    {3'b100, 48'hFFFFFFFFFFFF, 3'b000},
    {3'b101, 48'hFFFFFFFFFFFF, 3'b110},
    {3'b010, 48'h665544332210, 3'b000},
    {3'b000, 48'h000000000000, 3'b000}
  };

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int a = 0; a < 1024; a++) mem[a] = memval(a * 2);
    repeat (3) @(negedge clk);
    chk("R5 reset busy", 64'(load_busy), 64'h0);
    chk("R6 reset req", 64'(mem_req_valid), 64'h0);
    chk("R5 reset irq", 64'(irq_set), 64'h0);
    chk("R4 reset mask", 64'(enable_mask), 64'h0);
    chk("R12 reset out valid", 64'(flt_out_valid), 64'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // Load A: 16-bit mode, count with upper bits set, low bits 3
    run_load(32'h100, 16'hFFE3, 1'b0, "loadA");
    chk("R1 loadA read count", 64'(nlog), 64'd10);
    for (int e = 0; e < 3; e++)
      for (int k = 1; k < 4; k++)
        chk("R2 R3 loadA addr", 64'(req_log[e*3 + k - 1]), 64'(32'h100 + e*8 + k*2));
    chk("R4 loadA mask addr", 64'(req_log[9]), 64'h118);
    chk("R4 loadA mask", 64'(enable_mask), 64'(memval(32'h118)));
    dev_in_reset = 1'b1;
    for (int e = 0; e < 3; e++)
      for (int j = 0; j < 3; j++) begin
        rd_ptr = 16'(16'hFFF0 | e); rd_sel = 2'(j);
        @(negedge clk);
        chk("R13 R2 loadA readback", 64'(rd_data), 64'(memval(32'h100 + e*8 + (j+1)*2)));
      end
    rd_ptr = 16'h0003; rd_sel = 2'd0;
    @(negedge clk);
    chk("R1 entry3 untouched", 64'(rd_data), 64'h0);
    rd_ptr = 16'h0000; rd_sel = 2'd3;
    @(negedge clk);
    chk("R13 unused select", 64'(rd_data), 64'h0);
    dev_in_reset = 1'b0;
    rd_sel = 2'd0;
    @(negedge clk);
    chk("R13 gated outside reset", 64'(rd_data), 64'h0);

    // Load B: 32-bit mode, four known addresses, mask enables entries 0 and 2
    begin
      logic [47:0] macs [4];
      macs[0] = 48'h554433221102; macs[1] = 48'hEEDDCCBBAA02;
      macs[2] = 48'h0700005E0001; macs[3] = 48'h050403020106;
      for (int e = 0; e < 4; e++)
        for (int k = 1; k < 4; k++)
          mem[(32'h200 + e*16 + k*4) >> 1] = macs[e][(k-1)*16 +: 16];
      mem[32'h240 >> 1] = 16'h0005;
      mem[32'h300 >> 1] = 16'h0005;
      run_load(32'h200, 16'h0004, 1'b1, "loadB");
      chk("R1 loadB read count", 64'(nlog), 64'd13);
      for (int e = 0; e < 4; e++)
        for (int k = 1; k < 4; k++)
          chk("R2 R3 loadB addr", 64'(req_log[e*3 + k - 1]), 64'(32'h200 + e*16 + k*4));
      chk("R4 loadB mask addr", 64'(req_log[12]), 64'h240);
      chk("R4 loadB mask", 64'(enable_mask), 64'h0005);
      dev_in_reset = 1'b1;
      rd_ptr = 16'h0001; rd_sel = 2'd2;
      @(negedge clk);
      chk("R13 byte order entry1", 64'(rd_data), 64'hEEDD);
      dev_in_reset = 1'b0;
    end

    // Load C: zero count, only the mask read
    run_load(32'h300, 16'h0020, 1'b0, "loadC");
    chk("R4 zero count reads", 64'(nlog), 64'd1);
    chk("R4 zero count addr", 64'(req_log[0]), 64'h300);

    // Filter vector table
    for (int v = 0; v < 14; v++) begin
      @(negedge clk);
      {mode_promisc, mode_allmc, mode_bcast} = VEC[v][53:51];
      flt_da = VEC[v][50:3];
      flt_valid = 1'b1;
      @(negedge clk);
      flt_valid = 1'b0;
      chk("R12 out valid", 64'(flt_out_valid), 64'h1);
      chk("R7 R8 R9 R10 R11 filter result", 64'({flt_accept, flt_is_bcast, flt_is_mcast}),
          64'(VEC[v][2:0]));
    end
    @(negedge clk);
    chk("R12 out valid idle", 64'(flt_out_valid), 64'h0);
    chk("R11 idle accept", 64'(flt_accept), 64'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule